// File: doc/BRIEF.md
# H-Bridge Direction/Drive Gate Controller

This block turns a small set of control inputs (a direction bit, a drive-enable bit, two decay-style bits, an awake request and a supervisor kill line) into the four switch commands of a full H-bridge: a high and a low switch for each of the two half-bridges, named A and B. Each half-bridge is held in one of three states, high, low or off. The states are registered, so the gate commands follow the inputs on the clock edge after those inputs settle.

When drive is off, the block recirculates the winding current in one of three styles. Fast decay turns on the opposite diagonal. Slow decay shorts the winding through either both low switches or both high switches. In fast decay, a digital zero-current flag floats the bridge, so the current cannot swing past zero and reverse.

Every change of side on a half-bridge passes through an off interval of a parameterised number of clock cycles. The high and low switch of the same half are therefore never on together. Direction or drive-enable may be pulsed as a PWM, and drive may also be held on indefinitely.

Top module: `hbg_ctrl`

## Requirements
- R1: While `awake_i` is 0, all four gate outputs are 0 from the next clock edge on, whatever the other inputs are.
- R2: With `drive_en_i`=1, `dir_i`=1 gives A high, B low (`gate_a_hi_o`=1, `gate_b_lo_o`=1), and `dir_i`=0 gives A low, B high (`gate_a_lo_o`=1, `gate_b_hi_o`=1).
- R3: With `drive_en_i`=0 and `slow_dcy_i`=0 (fast decay), `dir_i`=0 gives A high and B low, and `dir_i`=1 gives A low and B high.
- R4: With `drive_en_i`=0 and `slow_dcy_i`=1, `hs_recirc_i`=0 turns on both low switches and `hs_recirc_i`=1 turns on both high switches. `hs_recirc_i` has no effect on the outputs when `slow_dcy_i`=0.
- R5: In fast decay, `zero_cur_i`=1 latches a float state, and both halves are off from the second clock edge on. `zero_cur_i` has no effect outside fast decay.
- R6: The float state is held while fast decay lasts, even after `zero_cur_i` returns to 0. It clears as soon as `drive_en_i` goes to 1, `slow_dcy_i` goes to 1, `awake_i` goes to 0 or `kill_i` goes to 1.
- R7: The high and low switch of one half-bridge are never both 1 in the same cycle.
- R8: When a half goes from one side to the other, its outputs stay 0 for exactly `DEAD_CYC` cycles before the new side turns on. A return to the side last used, or a change of target during the off interval, heads directly for the newest target, and the count is not reset.
- R9: While `kill_i` is 1, all four gate outputs are 0 from the next clock edge on.
- R10: After a synchronous reset (`rst_n`=0 at a clock edge), all gate outputs are 0, the float state is clear and no dead interval is pending.
- R11: With drive enabled and the direction held, the drive state is held for any number of cycles, which gives a 100% duty cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| awake_i | input | 1 | 1 = operate, 0 = all switches off |
| kill_i | input | 1 | Supervisor disable, 1 = all switches off |
| dir_i | input | 1 | Direction select |
| drive_en_i | input | 1 | 1 = drive, 0 = decay |
| slow_dcy_i | input | 1 | Decay style: 0 fast, 1 slow |
| hs_recirc_i | input | 1 | Slow-decay path: 0 low switches, 1 high switches |
| zero_cur_i | input | 1 | Winding current has reached zero |
| gate_a_hi_o | output | 1 | Half A high switch on |
| gate_a_lo_o | output | 1 | Half A low switch on |
| gate_b_hi_o | output | 1 | Half B high switch on |
| gate_b_lo_o | output | 1 | Half B low switch on |

## Verification
Assertions check four things on every cycle:
- no half-bridge ever has its high and low switch on together;
- no half moves from one side straight to the other without an off cycle;
- the awake and kill lines turn the bridge off within one edge;
- the float state is set and cleared by the fast-decay conditions.

The exact length of the dead interval, the restart toward the newest target, and the float latching past a dropped flag can only be shown by the bench's scenarios. The same holds for the decode of every drive and decay combination. The bench compares all four outputs against a behavioural model on every clock.

// File: rtl/hbg_pkg.sv
// Shared types for the H-bridge gate controller.
// Assumes: nothing beyond IEEE 1800-2017.
package hbg_pkg;

    // Drive state of one half-bridge.
    typedef enum logic [1:0] {
        LEG_OFF  = 2'd0,
        LEG_HIGH = 2'd1,
        LEG_LOW  = 2'd2
    } leg_state_e;

endpackage

// File: rtl/hbg_mode_decode.sv
// Combinational decode of the control inputs into a target state per half.
// Assumes: float_i is the registered float state from hbg_zero_hold.
module hbg_mode_decode
    import hbg_pkg::*;
(
    input  logic       awake_i,
    input  logic       kill_i,
    input  logic       dir_i,
    input  logic       drive_en_i,
    input  logic       slow_dcy_i,
    input  logic       hs_recirc_i,
    input  logic       float_i,
    output leg_state_e tgt_a_o,
    output leg_state_e tgt_b_o,
    output logic       fast_o
);

    // Fast decay is only active while the bridge is allowed to run.
    always_comb begin
        fast_o = awake_i && !kill_i && !drive_en_i && !slow_dcy_i;
    end

    // Select the per-half target for the current mode.
    always_comb begin
        tgt_a_o = LEG_OFF;
        tgt_b_o = LEG_OFF;
        if (!awake_i || kill_i) begin
            tgt_a_o = LEG_OFF;
            tgt_b_o = LEG_OFF;
        end else if (drive_en_i) begin
            tgt_a_o = dir_i ? LEG_HIGH : LEG_LOW;
            tgt_b_o = dir_i ? LEG_LOW  : LEG_HIGH;
        end else if (!slow_dcy_i) begin
            if (float_i) begin
                tgt_a_o = LEG_OFF;
                tgt_b_o = LEG_OFF;
            end else begin
                tgt_a_o = dir_i ? LEG_LOW  : LEG_HIGH;
                tgt_b_o = dir_i ? LEG_HIGH : LEG_LOW;
            end
        end else begin
            tgt_a_o = hs_recirc_i ? LEG_HIGH : LEG_LOW;
            tgt_b_o = hs_recirc_i ? LEG_HIGH : LEG_LOW;
        end
    end

endmodule

// File: rtl/hbg_zero_hold.sv
// Latches the zero-current float state during fast decay.
// Assumes: fast_i is high only while fast decay is commanded.
module hbg_zero_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic fast_i,
    input  logic zero_i,
    output logic float_o
);

    logic float_q;

    // Set on the zero flag in fast decay, hold while fast decay lasts.
    always_ff @(posedge clk) begin
        if (!rst_n) float_q <= 1'b0;
        else        float_q <= fast_i && (float_q || zero_i);
    end

    assign float_o = float_q;

    p_float_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_i && zero_i) |=> float_o);

    p_float_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !fast_i |=> !float_o);

endmodule

// File: rtl/hbg_leg.sv
// One half-bridge: follows its target state, inserting DEAD_CYC off cycles
// whenever it changes side.
// Assumes: DEAD_CYC >= 1; the target may change on any cycle.
module hbg_leg
    import hbg_pkg::*;
#(
    parameter int DEAD_CYC = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  leg_state_e tgt_i,
    output logic       hi_o,
    output logic       lo_o
);

    localparam int CW = $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(DEAD_CYC - 1);

    leg_state_e     cur_q;
    leg_state_e     last_q;
    logic [CW-1:0]  cnt_q;

    // State, last-used side and dead counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= LEG_OFF;
            last_q <= LEG_OFF;
            cnt_q  <= '0;
        end else if (tgt_i == LEG_OFF) begin
            if (cur_q != LEG_OFF) begin
                last_q <= cur_q;
                cnt_q  <= LOAD;
                cur_q  <= LEG_OFF;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end else if (tgt_i == cur_q) begin
            cur_q <= cur_q;
        end else if (cur_q != LEG_OFF) begin
            last_q <= cur_q;
            cnt_q  <= LOAD;
            cur_q  <= LEG_OFF;
        end else if (cnt_q == '0 || tgt_i == last_q) begin
            cur_q <= tgt_i;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Switch commands from the state.
    assign hi_o = (cur_q == LEG_HIGH);
    assign lo_o = (cur_q == LEG_LOW);

    p_no_shoot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_o && lo_o));

    p_gap_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hi_o |-> !$past(lo_o));

    p_gap_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lo_o |-> !$past(hi_o));

endmodule

// File: rtl/hbg_ctrl.sv
// Top of the H-bridge gate controller: decode, float latch and two legs.
// Assumes: inputs are synchronous to clk; the reset is synchronous, active low.
module hbg_ctrl
    import hbg_pkg::*;
#(
    parameter int DEAD_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic awake_i,
    input  logic kill_i,
    input  logic dir_i,
    input  logic drive_en_i,
    input  logic slow_dcy_i,
    input  logic hs_recirc_i,
    input  logic zero_cur_i,
    output logic gate_a_hi_o,
    output logic gate_a_lo_o,
    output logic gate_b_hi_o,
    output logic gate_b_lo_o
);

    localparam int NLEG = 2;

    leg_state_e tgt [NLEG];
    logic       hi  [NLEG];
    logic       lo  [NLEG];
    logic       fast;
    logic       float_st;

    hbg_mode_decode u_dec (
        .awake_i     (awake_i),
        .kill_i      (kill_i),
        .dir_i       (dir_i),
        .drive_en_i  (drive_en_i),
        .slow_dcy_i  (slow_dcy_i),
        .hs_recirc_i (hs_recirc_i),
        .float_i     (float_st),
        .tgt_a_o     (tgt[0]),
        .tgt_b_o     (tgt[1]),
        .fast_o      (fast)
    );

    hbg_zero_hold u_zero (
        .clk     (clk),
        .rst_n   (rst_n),
        .fast_i  (fast),
        .zero_i  (zero_cur_i),
        .float_o (float_st)
    );

    for (genvar g = 0; g < NLEG; g++) begin : g_leg
        hbg_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
            .clk   (clk),
            .rst_n (rst_n),
            .tgt_i (tgt[g]),
            .hi_o  (hi[g]),
            .lo_o  (lo[g])
        );
    end

    assign gate_a_hi_o = hi[0];
    assign gate_a_lo_o = lo[0];
    assign gate_b_hi_o = hi[1];
    assign gate_b_lo_o = lo[1];

    p_sleep_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !awake_i |=> !(gate_a_hi_o || gate_a_lo_o || gate_b_hi_o || gate_b_lo_o));

    p_kill_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        kill_i |=> !(gate_a_hi_o || gate_a_lo_o || gate_b_hi_o || gate_b_lo_o));

endmodule

// File: tb/hbg_ctrl_tb.sv
module hbg_ctrl_tb;

    localparam int D = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic awake = 1'b0, kill = 1'b0, dir = 1'b0, en = 1'b0;
    logic slow = 1'b0, hs = 1'b0, zero = 1'b0;
    logic a_hi, a_lo, b_hi, b_lo;

    always #2.5 clk = ~clk;

    hbg_ctrl #(.DEAD_CYC(D)) u_dut (
        .clk(clk), .rst_n(rst_n), .awake_i(awake), .kill_i(kill),
        .dir_i(dir), .drive_en_i(en), .slow_dcy_i(slow), .hs_recirc_i(hs),
        .zero_cur_i(zero),
        .gate_a_hi_o(a_hi), .gate_a_lo_o(a_lo),
        .gate_b_hi_o(b_hi), .gate_b_lo_o(b_lo)
    );

    int    n_chk = 0;
    int    n_err = 0;
    string tag = "R10";
    bit    cmp_on = 1'b0;
    int    cyc = 0;

    // Behavioural model: 0 off, 1 high, 2 low.
    int m_cur [2];
    int m_last[2];
    int m_cnt [2];
    bit m_float;

    function automatic void step_leg(int i, int t);
        if (t == 0) begin
            if (m_cur[i] != 0) begin
                m_last[i] = m_cur[i]; m_cnt[i] = D - 1; m_cur[i] = 0;
            end else if (m_cnt[i] > 0) m_cnt[i]--;
        end else if (t == m_cur[i]) begin
        end else if (m_cur[i] != 0) begin
            m_last[i] = m_cur[i]; m_cnt[i] = D - 1; m_cur[i] = 0;
        end else if (m_cnt[i] == 0 || t == m_last[i]) m_cur[i] = t;
        else m_cnt[i]--;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_cur[i] = 0; m_last[i] = 0; m_cnt[i] = 0;
            end
            m_float = 0;
        end else begin
            int ta, tb;
            bit fst;
            fst = awake && !kill && !en && !slow;
            if (!awake || kill)   begin ta = 0; tb = 0; end
            else if (en)          begin ta = dir ? 1 : 2; tb = dir ? 2 : 1; end
            else if (!slow)       begin
                if (m_float)      begin ta = 0; tb = 0; end
                else              begin ta = dir ? 2 : 1; tb = dir ? 1 : 2; end
            end else              begin ta = hs ? 1 : 2; tb = ta; end
            step_leg(0, ta);
            step_leg(1, tb);
            m_float = fst && (m_float || zero);
        end
    end

    task automatic check(string req, logic act, logic exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0b expected=%0b at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    // Compare all outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            check(tag, a_hi, m_cur[0] == 1, "a_hi");
            check(tag, a_lo, m_cur[0] == 2, "a_lo");
            check(tag, b_hi, m_cur[1] == 1, "b_hi");
            check(tag, b_lo, m_cur[1] == 2, "b_lo");
            check("R7", (a_hi && a_lo) || (b_hi && b_lo), 1'b0, "shoot-through");
        end
    end

    task automatic run(string t, int n);
        tag = t;
        repeat (n) @(negedge clk);
    endtask

    task automatic expect4(string req, logic ah, logic al, logic bh, logic bl);
        check(req, a_hi, ah, "a_hi"); check(req, a_lo, al, "a_lo");
        check(req, b_hi, bh, "b_hi"); check(req, b_lo, bl, "b_lo");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        awake = 1'b1; en = 1'b1; dir = 1'b1;
        repeat (3) @(negedge clk);
        expect4("R10", 0, 0, 0, 0);          // reset state
        cmp_on = 1'b1;
        rst_n = 1'b1;
        run("R2", 2);
        expect4("R2", 1, 0, 0, 1);           // forward
        run("R11", 40);
        expect4("R11", 1, 0, 0, 1);          // held drive
        dir = 1'b0; @(negedge clk);
        expect4("R8", 0, 0, 0, 0);           // dead interval starts
        run("R8", D - 1);
        expect4("R8", 0, 0, 0, 0);
        run("R2", 1);
        expect4("R2", 0, 1, 1, 0);           // reverse after D off cycles
        run("R2", 5);
        // fast decay from reverse (opposite diagonal)
        en = 1'b0; slow = 1'b0; dir = 1'b0;
        run("R3", D + 3);
        expect4("R3", 1, 0, 0, 1);
        dir = 1'b1; hs = 1'b1;               // mode2 ignored in fast decay
        run("R3", D + 3);
        expect4("R4", 0, 1, 1, 0);
        hs = 1'b0; run("R4", 3);
        expect4("R4", 0, 1, 1, 0);
        // zero flag: two edges to float
        zero = 1'b1; @(negedge clk);
        expect4("R5", 0, 1, 1, 0);
        @(negedge clk);
        expect4("R5", 0, 0, 0, 0);
        zero = 1'b0; run("R6", 5);
        expect4("R6", 0, 0, 0, 0);           // latched past flag drop
        en = 1'b1; run("R6", D + 3);
        expect4("R6", 1, 0, 0, 1);           // float cleared by drive
        zero = 1'b1; run("R5", 6);
        expect4("R5", 1, 0, 0, 1);           // flag ignored in drive
        // slow decay low then high
        en = 1'b0; slow = 1'b1; hs = 1'b0;
        run("R4", D + 3);
        expect4("R4", 0, 1, 0, 1);
        hs = 1'b1; run("R4", D + 3);
        expect4("R4", 1, 0, 1, 0);
        // float, then mode change clears it
        slow = 1'b0; dir = 1'b0; run("R5", D + 4);
        expect4("R5", 0, 0, 0, 0);
        zero = 1'b0; slow = 1'b1; hs = 1'b1; run("R6", D + 3);
        expect4("R6", 1, 0, 1, 0);
        slow = 1'b0; run("R6", D + 3);
        expect4("R6", 1, 0, 0, 1);           // fast decay active again
        // rapid direction toggling in drive during dead time
        en = 1'b1;
        for (int k = 0; k < 12; k++) begin
            dir = ~dir; run("R8", 1 + (k % 3));
        end
        run("R8", 2 * D + 2);
        // kill and sleep
        kill = 1'b1; run("R9", 3);
        expect4("R9", 0, 0, 0, 0);
        kill = 1'b0; run("R2", D + 3);
        awake = 1'b0; hs = 1'b1; slow = 1'b1; en = 1'b0; run("R1", 3);
        expect4("R1", 0, 0, 0, 0);
        awake = 1'b1; run("R4", D + 3);
        awake = 1'b0; run("R1", 2);
        // reset mid-run
        awake = 1'b1; en = 1'b1; dir = 1'b1; run("R2", D + 3);
        rst_n = 1'b0; run("R10", 2);
        expect4("R10", 0, 0, 0, 0);
        rst_n = 1'b1; run("R10", 2);
        expect4("R10", 1, 0, 0, 1);          // no dead interval pending
        cmp_on = 1'b0;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule